// File: doc/BRIEF.md
# Multiplexed Address Register Unit

This block holds sixteen 16-bit pointer registers and places any one of them on an external address bus that is only 8 bits wide. A memory access is a short phase sequence. The upper byte of the chosen pointer is driven first. A one-clock strobe follows so that outside logic can capture that byte. The lower byte is driven last. An access can also add one to the pointer it used. The increment is applied within the same access and costs no extra clock, so a pointer can walk through memory one byte per access.

Software loads a pointer one byte at a time. Two separate write enables update the upper half and the lower half of a chosen register. Each half can change without touching the other, or both can load in the same clock.

The sequencer is a four-state machine:
- `PH_IDLE`: the bus is at 0x00 and requests are accepted.
- `PH_HIGH`: the upper byte is driven with the strobe low.
- `PH_STROBE`: the upper byte is still driven and the strobe is high.
- `PH_LOW`: the lower byte is driven and the optional increment is applied.

The transitions are:
- IDLE→HIGH when a request is accepted.
- HIGH→STROBE unconditionally.
- STROBE→LOW unconditionally.
- LOW→IDLE unconditionally.

Top module: `amr_top`

## Requirements
- R1: After reset all sixteen registers read as 0x0000 on their first access, `abus` is 0x00, and `hi_stb`, `lo_phase` and `busy` are 0.
- R2: A request accepted at a clock edge gives three phases in the next three clocks:
  - HIGH: `abus` holds address bits 15:8, `hi_stb`=0, `busy`=1.
  - STROBE: `abus` holds bits 15:8, `hi_stb`=1.
  - LOW: `abus` holds bits 7:0, `lo_phase`=1.
  The unit then returns to idle, where `busy`=0 and `abus`=0x00.
- R3: `hi_stb` is high for exactly one clock per access, and `abus` holds the same upper byte in the clock before the strobe and during it.
- R4: `acc_sel` (0..15) chooses which register supplies the address, and the registers are independent of one another.
- R5: With `acc_inc`=1, the register used is increased by one over all 16 bits, wrapping 0xFFFF to 0x0000 and carrying from the low byte into the high byte. The new value is seen by the very next access, with no extra clock added.
- R6: With `acc_inc`=0, an access leaves the register unchanged.
- R7: `wr_hi_en` loads `wr_byte` into bits 15:8 of register `wr_sel` and leaves bits 7:0 unchanged. `wr_lo_en` loads bits 7:0 and leaves bits 15:8 unchanged. When both enables are set, both halves load in the same clock.
- R8: `acc_req` is ignored while `busy`=1. A request is taken only in idle, so back-to-back accesses start every fourth clock.
- R9: A byte write to the register being post-incremented, made in its LOW clock, takes priority and the increment is discarded. The address of an access in progress is latched and is not changed by writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Start an access (taken only when idle) |
| acc_sel | input | 4 | Register supplying the address |
| acc_inc | input | 1 | Post-increment the selected register |
| wr_hi_en | input | 1 | Load upper byte of register `wr_sel` |
| wr_lo_en | input | 1 | Load lower byte of register `wr_sel` |
| wr_sel | input | 4 | Register written by byte loads |
| wr_byte | input | 8 | Byte value for loads |
| abus | output | 8 | Multiplexed external address byte |
| hi_stb | output | 1 | Upper-byte latch strobe |
| lo_phase | output | 1 | Lower byte is on `abus` |
| busy | output | 1 | An access is in progress |

## Verification
Each pointer is loaded with a value whose upper and lower bytes differ. A swap of the two halves, or a strobe that lands on the wrong byte, would then show on the bus. Post-increment is tried on values with the following property:
- 0x12AB: a plain increment.
- 0x00FF: tests the carry into the upper byte.
- 0xFFFF: tests the wrap to zero.

Loading every register with a distinct pattern and reading each one back separates a select fault from a storage fault. Half-only writes, a request held during a busy access, and a write colliding with an increment in the LOW clock test the priority and ignore rules.

// File: rtl/amr_pkg.sv
package amr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_HIGH   = 2'd1,
        PH_STROBE = 2'd2,
        PH_LOW    = 2'd3
    } phase_t;
endpackage

// File: rtl/amr_regbank.sv
module amr_regbank #(
    parameter int NUM_REGS = 16,
    parameter int BUS_W    = 8,
    localparam int ADDR_W  = 2 * BUS_W,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi_en,
    input  logic              wr_lo_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BUS_W-1:0]  wr_byte,
    input  logic              inc_en,
    input  logic [SEL_W-1:0]  inc_sel,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [ADDR_W-1:0] ptr [NUM_REGS];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_ptr
        logic hit_wr;
        logic hit_inc;
        assign hit_wr  = (wr_hi_en || wr_lo_en) && (wr_sel == SEL_W'(gi));
        assign hit_inc = inc_en && (inc_sel == SEL_W'(gi));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr[gi] <= '0;
            end else if (hit_wr) begin
                if (wr_hi_en) ptr[gi][ADDR_W-1:BUS_W] <= wr_byte;
                if (wr_lo_en) ptr[gi][BUS_W-1:0]      <= wr_byte;
            end else if (hit_inc) begin
                ptr[gi] <= ptr[gi] + ADDR_W'(1);
            end
        end
    end

    assign rd_addr = ptr[rd_sel];
endmodule

// File: rtl/amr_phase_fsm.sv
module amr_phase_fsm
    import amr_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int BUS_W    = 8,
    localparam int ADDR_W  = 2 * BUS_W,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic              acc_inc,
    input  logic [ADDR_W-1:0] rd_addr,
    output phase_t            phase,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              inc_en,
    output logic [SEL_W-1:0]  inc_sel
);
    phase_t            state_q, state_d;
    logic              inc_q;
    logic [SEL_W-1:0]  sel_q;
    logic              accept;

    assign accept = (state_q == PH_IDLE) && acc_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (acc_req) state_d = PH_HIGH;
            PH_HIGH:   state_d = PH_STROBE;
            PH_STROBE: state_d = PH_LOW;
            PH_LOW:    state_d = PH_IDLE;
            default:   state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            inc_q    <= 1'b0;
            sel_q    <= '0;
        end else if (accept) begin
            cap_addr <= rd_addr;
            inc_q    <= acc_inc;
            sel_q    <= acc_sel;
        end
    end

    always_comb begin
        phase   = state_q;
        inc_en  = 1'b0;
        inc_sel = sel_q;
        unique case (state_q)
            PH_LOW:  inc_en = inc_q;
            default: inc_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/amr_bus_drive.sv
module amr_bus_drive
    import amr_pkg::*;
#(
    parameter int BUS_W   = 8,
    localparam int ADDR_W = 2 * BUS_W
) (
    input  phase_t            phase,
    input  logic [ADDR_W-1:0] cap_addr,
    output logic [BUS_W-1:0]  abus,
    output logic              hi_stb,
    output logic              lo_phase,
    output logic              busy
);
    always_comb begin
        abus     = '0;
        hi_stb   = 1'b0;
        lo_phase = 1'b0;
        busy     = 1'b1;
        unique case (phase)
            PH_IDLE:   busy = 1'b0;
            PH_HIGH:   abus = cap_addr[ADDR_W-1:BUS_W];
            PH_STROBE: begin
                abus   = cap_addr[ADDR_W-1:BUS_W];
                hi_stb = 1'b1;
            end
            PH_LOW: begin
                abus     = cap_addr[BUS_W-1:0];
                lo_phase = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/amr_top.sv
module amr_top
    import amr_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int BUS_W    = 8,
    localparam int ADDR_W  = 2 * BUS_W,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req,
    input  logic [SEL_W-1:0] acc_sel,
    input  logic             acc_inc,
    input  logic             wr_hi_en,
    input  logic             wr_lo_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [BUS_W-1:0] wr_byte,
    output logic [BUS_W-1:0] abus,
    output logic             hi_stb,
    output logic             lo_phase,
    output logic             busy
);
    phase_t            phase;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] cap_addr;
    logic              inc_en;
    logic [SEL_W-1:0]  inc_sel;

    amr_regbank #(.NUM_REGS(NUM_REGS), .BUS_W(BUS_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hi_en (wr_hi_en),
        .wr_lo_en (wr_lo_en),
        .wr_sel   (wr_sel),
        .wr_byte  (wr_byte),
        .inc_en   (inc_en),
        .inc_sel  (inc_sel),
        .rd_sel   (acc_sel),
        .rd_addr  (rd_addr)
    );

    amr_phase_fsm #(.NUM_REGS(NUM_REGS), .BUS_W(BUS_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_req  (acc_req),
        .acc_sel  (acc_sel),
        .acc_inc  (acc_inc),
        .rd_addr  (rd_addr),
        .phase    (phase),
        .cap_addr (cap_addr),
        .inc_en   (inc_en),
        .inc_sel  (inc_sel)
    );

    amr_bus_drive #(.BUS_W(BUS_W)) u_drive (
        .phase    (phase),
        .cap_addr (cap_addr),
        .abus     (abus),
        .hi_stb   (hi_stb),
        .lo_phase (lo_phase),
        .busy     (busy)
    );
endmodule

// File: rtl/amr_checker.sv
module amr_checker #(
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_req,
    input logic [BUS_W-1:0] abus,
    input logic             hi_stb,
    input logic             lo_phase,
    input logic             busy
);
    AST_STB_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        hi_stb |=> !hi_stb) else $error("strobe longer than one clock"); // R3

    AST_STB_HIGH_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hi_stb |-> $stable(abus)) else $error("upper byte moved at strobe"); // R3

    AST_STB_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        hi_stb |=> lo_phase) else $error("low phase missing after strobe"); // R2

    AST_LOW_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_phase |=> !busy) else $error("no return to idle"); // R2

    AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && acc_req) |=> (busy && !hi_stb && !lo_phase)) else $error("request not started"); // R2

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (abus == '0 && !hi_stb && !lo_phase)) else $error("idle bus not quiet"); // R1

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hi_stb, lo_phase})) else $error("phases overlap"); // R2

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !lo_phase) |=> busy) else $error("access cut short"); // R8
endmodule

bind amr_top amr_checker #(.BUS_W(BUS_W)) u_amr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_req  (acc_req),
    .abus     (abus),
    .hi_stb   (hi_stb),
    .lo_phase (lo_phase),
    .busy     (busy)
);

// File: tb/amr_top_tb.sv
module amr_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_req = 1'b0;
    logic [3:0] acc_sel = '0;
    logic       acc_inc = 1'b0;
    logic       wr_hi_en = 1'b0;
    logic       wr_lo_en = 1'b0;
    logic [3:0] wr_sel = '0;
    logic [7:0] wr_byte = '0;
    logic [7:0] abus;
    logic       hi_stb;
    logic       lo_phase;
    logic       busy;

    int checks = 0;
    int failures = 0;
    logic [15:0] model [16];

    always #2 clk = ~clk;

    amr_top u_dut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_sel(acc_sel),
        .acc_inc(acc_inc), .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en),
        .wr_sel(wr_sel), .wr_byte(wr_byte), .abus(abus), .hi_stb(hi_stb),
        .lo_phase(lo_phase), .busy(busy)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic hi, input logic lo, input logic [7:0] b);
        @(negedge clk);
        wr_sel = sel; wr_hi_en = hi; wr_lo_en = lo; wr_byte = b;
        @(negedge clk);
        wr_hi_en = 1'b0; wr_lo_en = 1'b0;
        if (hi) model[sel][15:8] = b;
        if (lo) model[sel][7:0] = b;
    endtask

    task automatic load(input logic [3:0] sel, input logic [15:0] v);
        wr(sel, 1'b1, 1'b0, v[15:8]);
        wr(sel, 1'b0, 1'b1, v[7:0]);
    endtask

    // full access with phase checks; model updated afterwards
    task automatic access(input string tag, input logic [3:0] sel, input logic inc);
        logic [15:0] e;
        e = model[sel];
        @(negedge clk);
        acc_req = 1'b1; acc_sel = sel; acc_inc = inc;
        @(negedge clk);
        acc_req = 1'b0;
        chk({tag, " R2 high phase"}, {abus, 5'd0, hi_stb, lo_phase, busy}, {e[15:8], 8'h01});
        @(negedge clk);
        chk({tag, " R3 strobe phase"}, {abus, 5'd0, hi_stb, lo_phase, busy}, {e[15:8], 8'h05});
        @(negedge clk);
        chk({tag, " R2 low phase"}, {abus, 5'd0, hi_stb, lo_phase, busy}, {e[7:0], 8'h03});
        @(negedge clk);
        chk({tag, " R2 idle after"}, {abus, 5'd0, hi_stb, lo_phase, busy}, 16'h0000);
        if (inc) model[sel] = model[sel] + 16'd1;
    endtask

    task automatic t_reset;
        chk("R1 outputs in reset", {abus, 5'd0, hi_stb, lo_phase, busy}, 16'h0000);
        access("R1 reg5 zero", 4'd5, 1'b0);
        access("R1 reg15 zero", 4'd15, 1'b0);
    endtask

    task automatic t_halves;
        load(4'd3, 16'h12AB);
        access("R7 load both halves", 4'd3, 1'b0);
        wr(4'd3, 1'b1, 1'b0, 8'h77);
        access("R7 high only", 4'd3, 1'b0);
        wr(4'd3, 1'b0, 1'b1, 8'h5C);
        access("R7 low only", 4'd3, 1'b0);
        wr(4'd3, 1'b1, 1'b1, 8'hE1);
        access("R7 both same clock", 4'd3, 1'b0);
    endtask

    task automatic t_inc;
        load(4'd7, 16'h12AB);
        access("R6 no increment", 4'd7, 1'b0);
        access("R6 still same", 4'd7, 1'b0);
        access("R5 increment use", 4'd7, 1'b1);
        access("R5 incremented seen", 4'd7, 1'b0);
        load(4'd8, 16'h00FF);
        access("R5 carry use", 4'd8, 1'b1);
        access("R5 carry seen", 4'd8, 1'b0);
        load(4'd9, 16'hFFFF);
        access("R5 wrap use", 4'd9, 1'b1);
        access("R5 wrap seen", 4'd9, 1'b0);
        access("R5 walk a", 4'd9, 1'b1);
        access("R5 walk b", 4'd9, 1'b1);
        access("R5 walk c", 4'd9, 1'b0);
    endtask

    task automatic t_all_regs;
        for (int i = 0; i < 16; i++) load(4'(i), {4'(i), 4'(15 - i), 4'(i ^ 5), 4'(i + 3)});
        for (int i = 0; i < 16; i++) access("R4 select", 4'(i), 1'b0);
    endtask

    task automatic t_busy_ignore;
        load(4'd2, 16'hA55A);
        load(4'd4, 16'h3CC3);
        @(negedge clk);
        acc_req = 1'b1; acc_sel = 4'd2; acc_inc = 1'b0;
        @(negedge clk);
        acc_sel = 4'd4; acc_inc = 1'b1;
        chk("R8 first access high", {8'd0, abus}, 16'h00A5);
        @(negedge clk);
        chk("R8 strobe unaffected", {8'd0, abus}, 16'h00A5);
        @(negedge clk);
        chk("R8 low byte of first", {8'd0, abus}, 16'h005A);
        acc_req = 1'b0;
        @(negedge clk);
        chk("R8 no second access", {15'd0, busy}, 16'h0000);
        access("R8 ignored reg untouched", 4'd4, 1'b0);
    endtask

    task automatic t_collide;
        load(4'd6, 16'h4000);
        @(negedge clk);
        acc_req = 1'b1; acc_sel = 4'd6; acc_inc = 1'b1;
        @(negedge clk);
        acc_req = 1'b0;
        wr_sel = 4'd6; wr_hi_en = 1'b1; wr_byte = 8'h99;
        @(negedge clk);
        wr_hi_en = 1'b0;
        chk("R9 latched high byte", {8'd0, abus}, 16'h0040);
        @(negedge clk);
        chk("R9 low byte", {8'd0, abus}, 16'h0000);
        wr_sel = 4'd6; wr_lo_en = 1'b1; wr_byte = 8'h21;
        @(negedge clk);
        wr_lo_en = 1'b0;
        model[6] = 16'h9921;
        access("R9 write wins over increment", 4'd6, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 16'h0000;
        repeat (3) @(negedge clk);
        t_reset_outputs_only();
        rst_n = 1'b1;
        t_reset;
        t_halves;
        t_inc;
        t_all_regs;
        t_busy_ignore;
        t_collide;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic t_reset_outputs_only;
        chk("R1 reset outputs held", {abus, 5'd0, hi_stb, lo_phase, busy}, 16'h0000);
    endtask
endmodule